// File: doc/BRIEF.md
# Region-Decoded Cache Access Controller

This block sits between a processor's memory port and an external memory port and decides, for every access, whether the cache takes part. The decision comes from the three most significant address bits. One region is cacheable and is served from a direct-mapped store of tags, valid bits and line data. Other regions bypass the store and go straight to external memory. Three regions are internal: one invalidates a matching line, and two give direct read and write access to the tag store and to the data store.

A small control register, written through its own port, holds an enable bit and a bit that stops instruction-fetch misses from allocating. Stores are write-through and never allocate. A read miss fills the whole line from external memory, one word at a time in ascending order, and then returns the requested word. The processor holds a request until it gets a one-cycle acknowledge. The external port holds a request until it gets a one-cycle acknowledge.

Top module: `region_cache`

## Requirements
- R1: After reset the control register reads 0 and the cache is off. A read in region 000 then makes exactly one external access and returns the memory word, and it leaves the line invalid.
- R2: With the enable bit (control bit 0) set, a region-000 read miss makes four external reads at line offsets 0x0, 0x4, 0x8 and 0xC, in that order, and returns the requested word. A later read of the same line makes no external access.
- R3: A store in region 000 makes one external write. On a hit it also updates the cached word. On a miss it leaves the line invalid.
- R4: Regions 001, 100, 101 and 111 always make one external access at the given address. They neither read nor change the store, so a cached copy can go stale.
- R5: An access in region 010 clears the valid bit of the indexed line only when the stored tag equals address bits 28 down to 10. It makes no external access.
- R6: Region 011 accesses the tag entry indexed by address bits 9 to 4. A read returns the tag in bits 28 to 10 and the valid bit in bit 0, with all other bits 0. A write loads the tag and the valid bit from the same positions.
- R7: Region 110 reads or writes the data word at index bits 9 to 4 and word bits 3 to 2. A word written there is returned by a region-000 hit on the line that matches the stored tag.
- R8: With both control bits set (bit 1 stops replacement), an instruction-fetch miss makes one external read and leaves the line invalid. Instruction-fetch hits are still served from the cache, and data-read misses still fill the line.
- R9: The control register reads back bit 0 (enable) and bit 1 (no replacement), with every other bit 0. While bit 0 is clear, bit 1 changes nothing.
- R10: An access uses the control value held on the cycle it is accepted. A control write in that same cycle takes effect from the next access.
- R11: The processor acknowledge lasts one cycle. An external request stays high, with a steady address, until the external acknowledge arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | Access request, held until cpu_ack |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_ifetch | input | 1 | Load is an instruction fetch |
| cpu_addr | input | 32 | Byte address, word aligned |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid with cpu_ack |
| cpu_ack | output | 1 | One-cycle completion pulse |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 32 | Control register write value |
| reg_rdata | output | 32 | Control register value |
| mem_req | output | 1 | External request, held until mem_ack |
| mem_we | output | 1 | External write |
| mem_addr | output | 32 | External byte address |
| mem_wdata | output | 32 | External write data |
| mem_rdata | input | 32 | External read data, valid with mem_ack |
| mem_ack | input | 1 | External completion pulse |

## Verification
A control-register write can land in the same cycle in which the controller accepts a processor access, so the access and the new setting meet on one clock edge. The bench provokes this on a line that was cached and then made stale through the bypass region. It raises the register strobe, clearing the enable bit, in the very cycle the cacheable load is presented. The load must still return the stale cached word with no external access, and the next load of the same address must go to memory and return the fresh word.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
   typedef enum logic [2:0] {
      K_CACHE,
      K_BYPASS,
      K_PURGE,
      K_TAGIO,
      K_DATAIO
   } kind_e;

   typedef enum logic [1:0] {
      S_IDLE,
      S_ACT,
      S_MEM,
      S_FILL
   } state_e;

   localparam int CTRL_EN    = 0;
   localparam int CTRL_NOREP = 1;
endpackage

// File: rtl/rcc_region_dec.sv
module rcc_region_dec
   import rcc_pkg::*;
(
   input  logic [2:0] region,
   input  logic       cache_on,
   output kind_e      kind
);
   always_comb begin
      unique case (region)
         3'b000:  kind = cache_on ? K_CACHE : K_BYPASS;
         3'b010:  kind = K_PURGE;
         3'b011:  kind = K_TAGIO;
         3'b110:  kind = K_DATAIO;
         default: kind = K_BYPASS;
      endcase
   end
endmodule

// File: rtl/rcc_array.sv
module rcc_array #(
   parameter int SETS  = 64,
   parameter int WORDS = 4,
   parameter int TAG_W = 19
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [$clog2(SETS)-1:0]   idx,
   input  logic [$clog2(WORDS)-1:0]  rd_word,
   output logic [TAG_W-1:0]          rd_tag,
   output logic                      rd_valid,
   output logic [31:0]               rd_data,
   input  logic                      tag_we,
   input  logic [TAG_W-1:0]          tag_wdata,
   input  logic                      valid_wdata,
   input  logic                      data_we,
   input  logic [$clog2(WORDS)-1:0]  wr_word,
   input  logic [31:0]               data_wdata
);
   localparam int IDX_W  = $clog2(SETS);
   localparam int WSEL_W = $clog2(WORDS);
   localparam int ENTRIES = SETS * WORDS;

   logic [TAG_W-1:0] tags  [SETS];
   logic [31:0]      words [ENTRIES];
   logic [SETS-1:0]  valid;

   for (genvar s = 0; s < SETS; s++) begin : g_valid
      logic v_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            v_q <= 1'b0;
         else if (tag_we && (idx == IDX_W'(s)))
            v_q <= valid_wdata;
      end
      assign valid[s] = v_q;
   end

   always_ff @(posedge clk) begin
      if (tag_we)
         tags[idx] <= tag_wdata;
   end

   always_ff @(posedge clk) begin
      if (data_we)
         words[{idx, wr_word}] <= data_wdata;
   end

   logic [IDX_W+WSEL_W-1:0] rd_sel;
   assign rd_sel   = {idx, rd_word};
   assign rd_tag   = tags[idx];
   assign rd_valid = valid[idx];
   assign rd_data  = words[rd_sel];
endmodule

// File: rtl/region_cache.sv
module region_cache
   import rcc_pkg::*;
#(
   parameter int SETS       = 64,
   parameter int LINE_WORDS = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cpu_req,
   input  logic        cpu_we,
   input  logic        cpu_ifetch,
   input  logic [31:0] cpu_addr,
   input  logic [31:0] cpu_wdata,
   output logic [31:0] cpu_rdata,
   output logic        cpu_ack,
   input  logic        reg_we,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        mem_req,
   output logic        mem_we,
   output logic [31:0] mem_addr,
   output logic [31:0] mem_wdata,
   input  logic [31:0] mem_rdata,
   input  logic        mem_ack
);
   localparam int IDX_W  = $clog2(SETS);
   localparam int WSEL_W = $clog2(LINE_WORDS);
   localparam int OFF_W  = WSEL_W + 2;
   localparam int TAG_LO = IDX_W + OFF_W;
   localparam int TAG_W  = 29 - TAG_LO;
   localparam logic [WSEL_W-1:0] LAST_WORD = WSEL_W'(LINE_WORDS - 1);

   if (((SETS & (SETS - 1)) != 0) || ((LINE_WORDS & (LINE_WORDS - 1)) != 0) ||
       (LINE_WORDS < 2) || (TAG_W < 1)) begin : g_bad_cfg
      $error("region_cache: SETS and LINE_WORDS must be powers of two that leave a tag");
   end

   // control register
   logic en_q, norep_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         norep_q <= 1'b0;
      end else if (reg_we) begin
         en_q    <= reg_wdata[CTRL_EN];
         norep_q <= reg_wdata[CTRL_NOREP];
      end
   end
   always_comb begin
      reg_rdata             = '0;
      reg_rdata[CTRL_EN]    = en_q;
      reg_rdata[CTRL_NOREP] = norep_q;
   end

   // accepted request
   state_e            state;
   logic [31:0]       q_addr, q_wdata;
   logic              q_we, q_if, q_en, q_norep;
   logic [WSEL_W-1:0] cnt;
   logic [31:0]       rdata_q;
   logic              ack_q;

   logic [IDX_W-1:0]  q_idx;
   logic [WSEL_W-1:0] q_word;
   logic [TAG_W-1:0]  q_tag;
   assign q_idx  = q_addr[TAG_LO-1:OFF_W];
   assign q_word = q_addr[OFF_W-1:2];
   assign q_tag  = q_addr[28:TAG_LO];

   kind_e kind;
   rcc_region_dec u_dec (
      .region   (q_addr[31:29]),
      .cache_on (q_en),
      .kind     (kind)
   );

   logic [TAG_W-1:0]  rd_tag, tag_wd;
   logic              rd_valid, tag_we, valid_wd, data_we;
   logic [31:0]       rd_data, data_wd;
   logic [WSEL_W-1:0] wr_word;

   rcc_array #(
      .SETS  (SETS),
      .WORDS (LINE_WORDS),
      .TAG_W (TAG_W)
   ) u_array (
      .clk         (clk),
      .rst_n       (rst_n),
      .idx         (q_idx),
      .rd_word     (q_word),
      .rd_tag      (rd_tag),
      .rd_valid    (rd_valid),
      .rd_data     (rd_data),
      .tag_we      (tag_we),
      .tag_wdata   (tag_wd),
      .valid_wdata (valid_wd),
      .data_we     (data_we),
      .wr_word     (wr_word),
      .data_wdata  (data_wd)
   );

   logic hit;
   assign hit = rd_valid && (rd_tag == q_tag);

   logic [31:0] tag_view;
   always_comb begin
      tag_view             = '0;
      tag_view[28:TAG_LO]  = rd_tag;
      tag_view[0]          = rd_valid;
   end

   // store write controls
   always_comb begin
      tag_we   = 1'b0;
      tag_wd   = q_tag;
      valid_wd = 1'b0;
      data_we  = 1'b0;
      wr_word  = q_word;
      data_wd  = q_wdata;
      if (state == S_ACT) begin
         unique case (kind)
            K_CACHE:  data_we = q_we && hit;
            K_PURGE:  begin
               tag_we = hit;
               tag_wd = rd_tag;
            end
            K_TAGIO:  begin
               tag_we   = q_we;
               tag_wd   = q_wdata[28:TAG_LO];
               valid_wd = q_wdata[0];
            end
            K_DATAIO: data_we = q_we;
            default:  ;
         endcase
      end else if ((state == S_FILL) && mem_ack) begin
         data_we  = 1'b1;
         wr_word  = cnt;
         data_wd  = mem_rdata;
         tag_we   = (cnt == LAST_WORD);
         valid_wd = 1'b1;
      end
   end

   // sequencing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         q_addr  <= '0;
         q_wdata <= '0;
         q_we    <= 1'b0;
         q_if    <= 1'b0;
         q_en    <= 1'b0;
         q_norep <= 1'b0;
         cnt     <= '0;
         rdata_q <= '0;
         ack_q   <= 1'b0;
      end else begin
         ack_q <= 1'b0;
         unique case (state)
            S_IDLE: if (cpu_req) begin
               q_addr  <= cpu_addr;
               q_wdata <= cpu_wdata;
               q_we    <= cpu_we;
               q_if    <= cpu_ifetch;
               q_en    <= en_q;
               q_norep <= norep_q;
               state   <= S_ACT;
            end
            S_ACT: begin
               unique case (kind)
                  K_CACHE: begin
                     if (q_we)
                        state <= S_MEM;
                     else if (hit) begin
                        rdata_q <= rd_data;
                        ack_q   <= 1'b1;
                        state   <= S_IDLE;
                     end else if (q_if && q_norep)
                        state <= S_MEM;
                     else begin
                        cnt   <= '0;
                        state <= S_FILL;
                     end
                  end
                  K_BYPASS: state <= S_MEM;
                  default: begin
                     rdata_q <= (kind == K_TAGIO && !q_we)  ? tag_view :
                                (kind == K_DATAIO && !q_we) ? rd_data : '0;
                     ack_q   <= 1'b1;
                     state   <= S_IDLE;
                  end
               endcase
            end
            S_MEM: if (mem_ack) begin
               rdata_q <= q_we ? '0 : mem_rdata;
               ack_q   <= 1'b1;
               state   <= S_IDLE;
            end
            S_FILL: if (mem_ack) begin
               if (cnt == q_word)
                  rdata_q <= mem_rdata;
               if (cnt == LAST_WORD) begin
                  ack_q <= 1'b1;
                  state <= S_IDLE;
               end
               cnt <= cnt + 1'b1;
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   assign cpu_rdata = rdata_q;
   assign cpu_ack   = ack_q;
   assign mem_req   = (state == S_MEM) || (state == S_FILL);
   assign mem_we    = (state == S_MEM) && q_we;
   assign mem_addr  = (state == S_FILL) ? {q_addr[31:OFF_W], cnt, 2'b00} : q_addr;
   assign mem_wdata = q_wdata;
endmodule

// File: rtl/rcc_chk.sv
module rcc_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        cpu_req,
   input logic [31:0] cpu_wdata,
   input logic        cpu_ack,
   input logic        mem_req,
   input logic        mem_we,
   input logic [31:0] mem_addr,
   input logic [31:0] mem_wdata,
   input logic        mem_ack
);
   // R11: processor acknowledge is a single-cycle pulse
   a_r11_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ack |=> !cpu_ack);

   // R11: acknowledge answers a request that was present
   a_r11_ack_has_req: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ack |-> $past(cpu_req));

   // R11: external request held steady until acknowledged
   a_r11_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   // R5, R6, R7: internal regions never reach external memory
   a_r5_internal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> ((mem_addr[31:29] != 3'b010) && (mem_addr[31:29] != 3'b011) &&
                   (mem_addr[31:29] != 3'b110)));

   // R3: write-through carries the processor's store data
   a_r3_store_data: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (mem_wdata == cpu_wdata));
endmodule

bind region_cache rcc_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cpu_req   (cpu_req),
   .cpu_wdata (cpu_wdata),
   .cpu_ack   (cpu_ack),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .mem_ack   (mem_ack)
);

// File: tb/region_cache_tb.sv
`timescale 1ns/1ps
module region_cache_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0, cpu_we = 1'b0, cpu_ifetch = 1'b0;
   logic [31:0] cpu_addr = '0, cpu_wdata = '0;
   logic [31:0] cpu_rdata;
   logic        cpu_ack;
   logic        reg_we = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic        mem_ack = 1'b0;

   always #4 clk = ~clk;

   region_cache u_dut (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_ifetch(cpu_ifetch),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_rdata(cpu_rdata), .cpu_ack(cpu_ack),
      .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
   );

   // external memory model: one-cycle acknowledge, low address bits only
   logic [31:0] mem_model [4096];
   int          beats = 0;
   logic [31:0] baddr [16];

   initial begin
      for (int i = 0; i < 4096; i++) mem_model[i] = 32'h5A00_0000 | i;
   end

   always @(posedge clk) begin
      if (mem_req && !mem_ack) begin
         mem_ack   <= 1'b1;
         mem_rdata <= mem_model[mem_addr[13:2]];
         if (mem_we) mem_model[mem_addr[13:2]] <= mem_wdata;
      end else begin
         mem_ack <= 1'b0;
      end
      if (mem_req && mem_ack) begin
         baddr[beats % 16] <= mem_addr;
         beats <= beats + 1;
      end
   end

   int vecs = 0, miss = 0;
   bit done = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vecs++;
      if (act !== exp) begin
         miss++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] mword(input logic [31:0] a);
      return mem_model[a[13:2]];
   endfunction

   task automatic access(input logic [31:0] a, input bit we, input bit fi,
                         input logic [31:0] wd, input bit rw, input logic [31:0] rv,
                         output logic [31:0] rd, output int nb);
      int b0;
      @(negedge clk);
      b0 = beats;
      cpu_req = 1'b1; cpu_we = we; cpu_ifetch = fi; cpu_addr = a; cpu_wdata = wd;
      reg_we = rw; reg_wdata = rv;
      @(negedge clk);
      reg_we = 1'b0;
      while (!cpu_ack) @(negedge clk);
      rd = cpu_rdata;
      nb = beats - b0;
      cpu_req = 1'b0; cpu_we = 1'b0; cpu_ifetch = 1'b0;
      @(negedge clk);
      chk("R11 ack one cycle", {31'b0, cpu_ack}, 32'h0);
   endtask

   task automatic rd_acc(input logic [31:0] a, input bit fi, output logic [31:0] rd, output int nb);
      access(a, 1'b0, fi, 32'h0, 1'b0, 32'h0, rd, nb);
   endtask

   task automatic wr_acc(input logic [31:0] a, input logic [31:0] wd, output int nb);
      logic [31:0] dummy;
      access(a, 1'b1, 1'b0, wd, 1'b0, 32'h0, dummy, nb);
   endtask

   task automatic set_ctrl(input logic [31:0] v);
      @(negedge clk);
      reg_we = 1'b1; reg_wdata = v;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   function automatic logic [31:0] tagaddr(input logic [31:0] a);
      return {3'b011, 19'b0, a[9:4], 4'b0};
   endfunction

   logic [31:0] r;
   int          n;

   task automatic t_reset();
      chk("R1 ctrl reset", reg_rdata, 32'h0);
      rd_acc(32'h0000_0104, 1'b0, r, n);
      chk("R1 disabled read beats", n, 1);
      chk("R1 disabled read data", r, 32'h5A00_0041);
      rd_acc(tagaddr(32'h104), 1'b0, r, n);
      chk("R1 line not allocated", r & 32'h1, 32'h0);
   endtask

   task automatic t_fill();
      int b0;
      set_ctrl(32'h1);
      chk("R9 ctrl readback en", reg_rdata, 32'h1);
      b0 = beats;
      rd_acc(32'h0000_0108, 1'b0, r, n);
      chk("R2 fill beats", n, 4);
      chk("R2 fill data", r, 32'h5A00_0042);
      for (int k = 0; k < 4; k++)
         chk("R2 fill order", baddr[(b0 + k) % 16], 32'h0000_0100 + 32'(4 * k));
      rd_acc(32'h0000_010C, 1'b0, r, n);
      chk("R2 hit beats", n, 0);
      chk("R2 hit data", r, 32'h5A00_0043);
      rd_acc(tagaddr(32'h100), 1'b0, r, n);
      chk("R6 tag view valid tag0", r, 32'h1);
   endtask

   task automatic t_through();
      wr_acc(32'h2000_0104, 32'hDEAD_0001, n);
      chk("R4 through write beats", n, 1);
      rd_acc(32'h0000_0104, 1'b0, r, n);
      chk("R4 cached copy stale", r, 32'h5A00_0041);
      chk("R4 stale hit beats", n, 0);
      rd_acc(32'h2000_0104, 1'b0, r, n);
      chk("R4 through read data", r, 32'hDEAD_0001);
      chk("R4 through read beats", n, 1);
      rd_acc(32'h8000_0104, 1'b0, r, n);
      chk("R4 region 100 data", r, 32'hDEAD_0001);
      rd_acc(32'hE000_0104, 1'b0, r, n);
      chk("R4 io region beats", n, 1);
   endtask

   task automatic t_wthru();
      wr_acc(32'h0000_0108, 32'h1234_5678, n);
      chk("R3 write hit beats", n, 1);
      rd_acc(32'h0000_0108, 1'b0, r, n);
      chk("R3 cache updated", r, 32'h1234_5678);
      chk("R3 updated hit beats", n, 0);
      chk("R3 memory updated", mword(32'h108), 32'h1234_5678);
      wr_acc(32'h0000_0204, 32'h0BAD_F00D, n);
      chk("R3 write miss beats", n, 1);
      rd_acc(tagaddr(32'h200), 1'b0, r, n);
      chk("R3 write miss no allocate", r & 32'h1, 32'h0);
   endtask

   task automatic t_purge();
      rd_acc(32'h4000_0500, 1'b0, r, n);
      chk("R5 purge beats", n, 0);
      rd_acc(tagaddr(32'h100), 1'b0, r, n);
      chk("R5 mismatched purge keeps line", r & 32'h1, 32'h1);
      wr_acc(32'h4000_0104, 32'h0, n);
      rd_acc(tagaddr(32'h100), 1'b0, r, n);
      chk("R5 matching purge clears", r & 32'h1, 32'h0);
      rd_acc(32'h0000_0104, 1'b0, r, n);
      chk("R5 refill beats", n, 4);
      chk("R5 refill data fresh", r, 32'hDEAD_0001);
   endtask

   task automatic t_direct();
      wr_acc(32'hC000_0304, 32'h0000_CAFE, n);
      chk("R7 data write beats", n, 0);
      rd_acc(32'hC000_0304, 1'b0, r, n);
      chk("R7 data readback", r, 32'h0000_CAFE);
      wr_acc(32'h6000_0300, 32'h0000_1401, n);
      rd_acc(32'h6000_0300, 1'b0, r, n);
      chk("R6 tag readback", r, 32'h0000_1401);
      rd_acc(32'h0000_1704, 1'b0, r, n);
      chk("R7 hit on planted word", r, 32'h0000_CAFE);
      chk("R7 planted hit beats", n, 0);
   endtask

   task automatic t_norep();
      set_ctrl(32'hFFFF_FFFF);
      chk("R9 other bits read 0", reg_rdata, 32'h3);
      rd_acc(32'h0000_0404, 1'b1, r, n);
      chk("R8 ifetch miss beats", n, 1);
      chk("R8 ifetch miss data", r, 32'h5A00_0101);
      rd_acc(tagaddr(32'h400), 1'b0, r, n);
      chk("R8 ifetch miss no allocate", r & 32'h1, 32'h0);
      rd_acc(32'h0000_0108, 1'b1, r, n);
      chk("R8 ifetch hit data", r, 32'h1234_5678);
      chk("R8 ifetch hit beats", n, 0);
      rd_acc(32'h0000_0404, 1'b0, r, n);
      chk("R8 data miss fills", n, 4);
   endtask

   task automatic t_norep_off();
      set_ctrl(32'h2);
      rd_acc(32'h0000_0054, 1'b1, r, n);
      chk("R9 disabled ifetch beats", n, 1);
      chk("R9 disabled ifetch data", r, 32'h5A00_0015);
      rd_acc(32'h0000_0054, 1'b0, r, n);
      chk("R9 disabled data read beats", n, 1);
      rd_acc(tagaddr(32'h50), 1'b0, r, n);
      chk("R9 disabled no allocate", r & 32'h1, 32'h0);
   endtask

   task automatic t_overlap();
      set_ctrl(32'h1);
      wr_acc(32'h2000_0104, 32'hBEEF_0002, n);
      access(32'h0000_0104, 1'b0, 1'b0, 32'h0, 1'b1, 32'h0, r, n);
      chk("R10 old control used", r, 32'hDEAD_0001);
      chk("R10 old control beats", n, 0);
      chk("R10 control now clear", reg_rdata, 32'h0);
      rd_acc(32'h0000_0104, 1'b0, r, n);
      chk("R10 next access bypasses", r, 32'hBEEF_0002);
      chk("R10 next access beats", n, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_fill();
      t_through();
      t_wthru();
      t_purge();
      t_direct();
      t_norep();
      t_norep_off();
      t_overlap();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         vecs++;
         miss++;
         $display("FAIL watchdog actual %0d expected %0d", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
         $finish;
      end
   end
endmodule